// File: doc/BRIEF.md
# Downward-Growing Stack Pointer Unit

This block keeps the 16-bit stack pointer of a small processor core. The stack grows toward lower addresses. The unit moves the pointer itself when the core strobes one of four stack operations: a one-byte data push, a one-byte data pop, a two-byte return-address push (call or interrupt entry) and a two-byte return-address pop (return or interrupt return). For each stack byte it presents a registered memory address with a write or read qualifier. For the two-byte operations it also marks which byte of the return address is moving.

Software sees the pointer as two byte-wide halves behind a small register port. A select line picks the half to read or write. A push whose write address falls below a configurable floor raises an error pulse with that write. The floor defaults to 0x0060, the start of general data memory. The memory array, the instruction decoder and the program counter sit outside this block.

Top module: `stkptr_unit`

## Requirements
- R1: After a synchronous reset the pointer is 0x0000, both halves read 0x00, and busy, mem_we, mem_re, mem_hi_byte, stk_err and mem_addr are all zero.
- R2: A software write with sw_hi_sel=0 loads bits 7:0 of the pointer, and with sw_hi_sel=1 loads bits 15:8, on the next clock edge. sw_rdata shows bits 7:0 when sw_hi_sel=0 and bits 15:8 when sw_hi_sel=1, without delay. Without a write or an operation, the pointer holds.
- R3: One cycle after a push_byte strobe, mem_we=1 and mem_addr equals the pointer before the strobe, and the pointer has dropped by one (write first, then decrement).
- R4: One cycle after a pop_byte strobe, mem_re=1, the pointer has risen by one, and mem_addr equals the new pointer (increment first, then read).
- R5: A push_ret strobe gives two consecutive write cycles. The first is at the old pointer P with mem_hi_byte=0. The second is at P-1 with mem_hi_byte=1. The pointer ends at P-2, and busy is high during the first of the two cycles.
- R6: A pop_ret strobe gives two consecutive read cycles. The first is at P+1 with mem_hi_byte=1. The second is at P+2 with mem_hi_byte=0. The pointer ends at P+2, and busy is high during the first of the two cycles.
- R7: Operation strobes are ignored while busy is high, and also when more than one strobe is high in the same cycle.
- R8: A software write in a cycle where the pointer is being adjusted has no effect: the adjustment wins and the written half is dropped.
- R9: stk_err is high, together with mem_we, exactly for a stack write whose address is below STACK_FLOOR (default 0x0060). The write still takes place.
- R10: Pointer arithmetic wraps modulo 2^16: a push at 0x0000 leaves 0xFFFF, and a pop at 0xFFFF leaves 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sw_we | input | 1 | Software write strobe for the selected pointer half |
| sw_hi_sel | input | 1 | Half select: 0 low byte, 1 high byte |
| sw_wdata | input | 8 | Software write data |
| sw_rdata | output | 8 | Selected pointer half |
| push_byte | input | 1 | One-byte data push strobe |
| pop_byte | input | 1 | One-byte data pop strobe |
| push_ret | input | 1 | Two-byte return-address push strobe |
| pop_ret | input | 1 | Two-byte return-address pop strobe |
| busy | output | 1 | Second byte of a two-byte operation pending |
| mem_addr | output | 16 | Stack byte address (zero when idle) |
| mem_we | output | 1 | Stack byte write at mem_addr |
| mem_re | output | 1 | Stack byte read at mem_addr |
| mem_hi_byte | output | 1 | Return-address byte being moved: 1 high, 0 low |
| stk_err | output | 1 | Stack write below the floor |

## Verification
Each memory access shows up on the registered outputs one clock after its strobe. The second byte of a return-address operation follows one clock later. The pointer, and so sw_rdata, changes at the same edge as the access it belongs to. A software write shows on sw_rdata after one edge. The bench applies inputs on the falling edge and advances a behavioural model at each rising edge. It compares every output with that model on the next falling edge, so each result is checked in the exact cycle it is due, and a late or early value is reported.

// File: rtl/stkptr_pkg.sv
package stkptr_pkg;
  typedef enum logic [2:0] {
    OP_NONE  = 3'd0,
    OP_PUSH1 = 3'd1,
    OP_POP1  = 3'd2,
    OP_PUSH2 = 3'd3,
    OP_POP2  = 3'd4
  } stk_op_e;

  typedef enum logic [1:0] {
    PH_IDLE    = 2'd0,
    PH_PUSH_HI = 2'd1,
    PH_POP_LO  = 2'd2
  } stk_phase_e;

  localparam int unsigned N_STROBES = 4;
endpackage

// File: rtl/stkptr_decode.sv
module stkptr_decode
  import stkptr_pkg::*;
(
  input  logic [N_STROBES-1:0] strobes,
  input  logic                 busy,
  output stk_op_e              op
);
  localparam int unsigned CNT_W = $clog2(N_STROBES + 1);

  logic [CNT_W-1:0] n_set;

  always_comb begin
    n_set = '0;
    for (int i = 0; i < N_STROBES; i++) begin
      n_set = n_set + CNT_W'(strobes[i]);
    end
  end

  // strobe order: 0 push one, 1 pop one, 2 push two, 3 pop two
  always_comb begin
    op = OP_NONE;
    if (!busy && n_set == CNT_W'(1)) begin
      unique case (1'b1)
        strobes[0]: op = OP_PUSH1;
        strobes[1]: op = OP_POP1;
        strobes[2]: op = OP_PUSH2;
        strobes[3]: op = OP_POP2;
        default:    op = OP_NONE;
      endcase
    end
  end
endmodule

// File: rtl/stkptr_seq.sv
module stkptr_seq
  import stkptr_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  stk_op_e op,
  output logic    step_dec,
  output logic    step_inc,
  output logic    hi_sel,
  output logic    busy
);
  stk_phase_e phase, phase_nx;

  always_comb begin
    step_dec = 1'b0;
    step_inc = 1'b0;
    hi_sel   = 1'b0;
    phase_nx = PH_IDLE;
    unique case (phase)
      PH_PUSH_HI: begin
        step_dec = 1'b1;
        hi_sel   = 1'b1;
      end
      PH_POP_LO: begin
        step_inc = 1'b1;
      end
      default: begin
        unique case (op)
          OP_PUSH1: step_dec = 1'b1;
          OP_POP1:  step_inc = 1'b1;
          OP_PUSH2: begin
            step_dec = 1'b1;
            phase_nx = PH_PUSH_HI;
          end
          OP_POP2: begin
            step_inc = 1'b1;
            hi_sel   = 1'b1;
            phase_nx = PH_POP_LO;
          end
          default: ;
        endcase
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) phase <= PH_IDLE;
    else     phase <= phase_nx;
  end

  assign busy = (phase != PH_IDLE);

  // R5: a two-byte push continues with the high byte one cycle later
  assert_push2_second_R5: assert property (@(posedge clk) disable iff (rst)
    (!busy && op == OP_PUSH2) |=> (busy && step_dec && hi_sel));

  // R6: a two-byte pop starts with the high byte and ends with the low byte
  assert_pop2_order_R6: assert property (@(posedge clk) disable iff (rst)
    (!busy && op == OP_POP2 && hi_sel) |=> (busy && step_inc && !hi_sel));

  // R7: the busy window lasts exactly one cycle
  assert_busy_single_R7: assert property (@(posedge clk) disable iff (rst)
    busy |=> !busy);
endmodule

// File: rtl/stkptr_reg.sv
module stkptr_reg #(
  parameter int unsigned BYTE_W = 8,
  localparam int unsigned PTR_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sw_we,
  input  logic              sw_hi_sel,
  input  logic [BYTE_W-1:0] sw_wdata,
  input  logic              dec,
  input  logic              inc,
  output logic [PTR_W-1:0]  sp
);
  always_ff @(posedge clk) begin
    if (rst) begin
      sp <= '0;
    end else if (dec) begin
      sp <= sp - PTR_W'(1);
    end else if (inc) begin
      sp <= sp + PTR_W'(1);
    end else if (sw_we) begin
      if (sw_hi_sel) sp[PTR_W-1:BYTE_W] <= sw_wdata;
      else           sp[BYTE_W-1:0]     <= sw_wdata;
    end
  end

  // R3: each decrement step lowers the pointer by one, wrapping (R10)
  assert_dec_step_R3: assert property (@(posedge clk) disable iff (rst)
    dec |=> (sp == PTR_W'($past(sp) - PTR_W'(1))));

  // R4: each increment step raises the pointer by one, wrapping (R10)
  assert_inc_step_R4: assert property (@(posedge clk) disable iff (rst)
    (inc && !dec) |=> (sp == PTR_W'($past(sp) + PTR_W'(1))));

  // R8: a software write never lands together with an adjustment
  assert_sw_dropped_R8: assert property (@(posedge clk) disable iff (rst)
    (sw_we && (dec || inc)) |=> (sp != $past(sp)));

  // R2: with nothing going on the pointer holds
  assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (!sw_we && !dec && !inc) |=> $stable(sp));
endmodule

// File: rtl/stkptr_unit.sv
module stkptr_unit
  import stkptr_pkg::*;
#(
  parameter int unsigned BYTE_W      = 8,
  parameter int unsigned STACK_FLOOR = 'h60,
  localparam int unsigned PTR_W      = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sw_we,
  input  logic              sw_hi_sel,
  input  logic [BYTE_W-1:0] sw_wdata,
  output logic [BYTE_W-1:0] sw_rdata,
  input  logic              push_byte,
  input  logic              pop_byte,
  input  logic              push_ret,
  input  logic              pop_ret,
  output logic              busy,
  output logic [PTR_W-1:0]  mem_addr,
  output logic              mem_we,
  output logic              mem_re,
  output logic              mem_hi_byte,
  output logic              stk_err
);
  localparam logic [PTR_W-1:0] FLOOR_ADDR = PTR_W'(STACK_FLOOR);

  stk_op_e          op;
  logic             step_dec, step_inc, hi_sel;
  logic [PTR_W-1:0] sp;

  stkptr_decode u_decode (
    .strobes ({pop_ret, push_ret, pop_byte, push_byte}),
    .busy    (busy),
    .op      (op)
  );

  stkptr_seq u_seq (
    .clk      (clk),
    .rst      (rst),
    .op       (op),
    .step_dec (step_dec),
    .step_inc (step_inc),
    .hi_sel   (hi_sel),
    .busy     (busy)
  );

  stkptr_reg #(.BYTE_W(BYTE_W)) u_reg (
    .clk       (clk),
    .rst       (rst),
    .sw_we     (sw_we),
    .sw_hi_sel (sw_hi_sel),
    .sw_wdata  (sw_wdata),
    .dec       (step_dec),
    .inc       (step_inc),
    .sp        (sp)
  );

  assign sw_rdata = sw_hi_sel ? sp[PTR_W-1:BYTE_W] : sp[BYTE_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_addr    <= '0;
      mem_we      <= 1'b0;
      mem_re      <= 1'b0;
      mem_hi_byte <= 1'b0;
      stk_err     <= 1'b0;
    end else begin
      mem_we      <= step_dec;
      mem_re      <= step_inc;
      mem_hi_byte <= hi_sel;
      stk_err     <= step_dec && (sp < FLOOR_ADDR);
      if (step_dec)      mem_addr <= sp;
      else if (step_inc) mem_addr <= sp + PTR_W'(1);
      else               mem_addr <= '0;
    end
  end

  // R9: an error pulse always comes with a stack write below the floor
  assert_err_on_write_R9: assert property (@(posedge clk) disable iff (rst)
    stk_err |-> (mem_we && mem_addr < FLOOR_ADDR));

  // R3: a write and a read are never issued together
  assert_we_re_excl_R3: assert property (@(posedge clk) disable iff (rst)
    !(mem_we && mem_re));

  // R4: a read address equals the pointer it leaves behind
  assert_pop_addr_R4: assert property (@(posedge clk) disable iff (rst)
    mem_re |-> (mem_addr == sp || busy));
endmodule

// File: tb/tb_stkptr_unit.sv
`timescale 1ns/1ps
module tb_stkptr_unit;
  localparam int unsigned FLOOR = 'h60;

  logic        clk = 1'b0;
  logic        rst;
  logic        sw_we, sw_hi_sel;
  logic [7:0]  sw_wdata;
  logic [7:0]  sw_rdata;
  logic        push_byte, pop_byte, push_ret, pop_ret;
  logic        busy;
  logic [15:0] mem_addr;
  logic        mem_we, mem_re, mem_hi_byte, stk_err;

  stkptr_unit dut (
    .clk(clk), .rst(rst), .sw_we(sw_we), .sw_hi_sel(sw_hi_sel),
    .sw_wdata(sw_wdata), .sw_rdata(sw_rdata), .push_byte(push_byte),
    .pop_byte(pop_byte), .push_ret(push_ret), .pop_ret(pop_ret),
    .busy(busy), .mem_addr(mem_addr), .mem_we(mem_we), .mem_re(mem_re),
    .mem_hi_byte(mem_hi_byte), .stk_err(stk_err)
  );

  always #5 clk = ~clk;

  int    checks = 0;
  int    errors = 0;
  bit    done   = 1'b0;
  string cur_req = "R1";

  // behavioural reference
  logic [15:0] m_sp;
  int          m_pend;   // 0 none, 1 high byte write due, 2 low byte read due
  logic [15:0] m_addr;
  logic        m_we, m_re, m_hi, m_err;

  task automatic model_edge();
    int n;
    bit adj;
    adj = 1'b0;
    m_we = 0; m_re = 0; m_hi = 0; m_err = 0; m_addr = 16'h0;
    if (rst) begin
      m_sp = 16'h0; m_pend = 0;
      return;
    end
    if (m_pend == 1) begin
      m_we = 1; m_hi = 1; m_addr = m_sp; m_err = (m_sp < FLOOR);
      m_sp = m_sp - 16'd1; m_pend = 0; adj = 1;
    end else if (m_pend == 2) begin
      m_sp = m_sp + 16'd1; m_re = 1; m_addr = m_sp; m_pend = 0; adj = 1;
    end else begin
      n = int'(push_byte) + int'(pop_byte) + int'(push_ret) + int'(pop_ret);
      if (n == 1) begin
        adj = 1;
        if (push_byte || push_ret) begin
          m_we = 1; m_addr = m_sp; m_err = (m_sp < FLOOR);
          m_sp = m_sp - 16'd1;
          if (push_ret) m_pend = 1;
        end else begin
          m_sp = m_sp + 16'd1; m_re = 1; m_addr = m_sp;
          if (pop_ret) begin m_hi = 1; m_pend = 2; end
        end
      end
    end
    if (!adj && sw_we) begin
      if (sw_hi_sel) m_sp[15:8] = sw_wdata;
      else           m_sp[7:0]  = sw_wdata;
    end
  endtask

  task automatic cmp(input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", cur_req, what, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    logic [7:0] exp_rd;
    exp_rd = sw_hi_sel ? m_sp[15:8] : m_sp[7:0];
    cmp("mem_addr", int'(mem_addr), int'(m_addr));
    cmp("mem_we", int'(mem_we), int'(m_we));
    cmp("mem_re", int'(mem_re), int'(m_re));
    cmp("mem_hi_byte", int'(mem_hi_byte), int'(m_hi));
    cmp("stk_err", int'(stk_err), int'(m_err));
    cmp("busy", int'(busy), int'(m_pend != 0));
    cmp("sw_rdata", int'(sw_rdata), int'(exp_rd));
  endtask

  // drive inputs at the falling edge, advance model at rising edge, compare at next falling edge
  task automatic cyc(input bit r, input bit we, input bit hs, input logic [7:0] wd,
                     input bit pu, input bit po, input bit pr, input bit rr);
    rst = r; sw_we = we; sw_hi_sel = hs; sw_wdata = wd;
    push_byte = pu; pop_byte = po; push_ret = pr; pop_ret = rr;
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare_all();
  endtask

  task automatic idle(input bit hs);
    cyc(0, 0, hs, 8'h00, 0, 0, 0, 0);
  endtask

  task automatic set_sp(input logic [15:0] v);
    cyc(0, 1, 0, v[7:0], 0, 0, 0, 0);
    cyc(0, 1, 1, v[15:8], 0, 0, 0, 0);
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    rst = 1; sw_we = 0; sw_hi_sel = 0; sw_wdata = 0;
    push_byte = 0; pop_byte = 0; push_ret = 0; pop_ret = 0;
    m_sp = 0; m_pend = 0; m_addr = 0; m_we = 0; m_re = 0; m_hi = 0; m_err = 0;
    @(negedge clk);
    cur_req = "R1";
    cyc(1, 0, 0, 8'h00, 0, 0, 0, 0);
    cyc(1, 0, 1, 8'h00, 0, 0, 0, 0);
    idle(0); idle(1);

    cur_req = "R2";
    set_sp(16'h0480);
    idle(0); idle(1);
    cyc(0, 1, 0, 8'h3C, 0, 0, 0, 0);
    idle(0); idle(1);

    cur_req = "R3";
    cyc(0, 0, 0, 8'h00, 1, 0, 0, 0);
    cyc(0, 0, 0, 8'h00, 1, 0, 0, 0);
    cyc(0, 0, 1, 8'h00, 1, 0, 0, 0);
    idle(0);

    cur_req = "R4";
    cyc(0, 0, 0, 8'h00, 0, 1, 0, 0);
    cyc(0, 0, 1, 8'h00, 0, 1, 0, 0);
    idle(0);

    cur_req = "R5";
    cyc(0, 0, 0, 8'h00, 0, 0, 1, 0);
    idle(0); idle(0);
    cyc(0, 0, 0, 8'h00, 0, 0, 1, 0);
    cyc(0, 0, 0, 8'h00, 0, 0, 1, 0);
    idle(0); idle(1);

    cur_req = "R6";
    cyc(0, 0, 0, 8'h00, 0, 0, 0, 1);
    idle(0); idle(0);
    cyc(0, 0, 0, 8'h00, 0, 0, 0, 1);
    idle(1); idle(0);

    cur_req = "R7";
    cyc(0, 0, 0, 8'h00, 0, 0, 1, 0);
    cyc(0, 0, 0, 8'h00, 1, 0, 0, 0);
    idle(0);
    cyc(0, 0, 0, 8'h00, 0, 0, 0, 1);
    cyc(0, 0, 0, 8'h00, 0, 1, 0, 0);
    idle(0);
    cyc(0, 0, 0, 8'h00, 1, 1, 0, 0);
    cyc(0, 0, 0, 8'h00, 0, 0, 1, 1);
    idle(0); idle(1);

    cur_req = "R8";
    cyc(0, 1, 0, 8'hAA, 1, 0, 0, 0);
    idle(0);
    cyc(0, 1, 1, 8'h55, 0, 1, 0, 0);
    idle(1);
    cyc(0, 0, 0, 8'h00, 0, 0, 1, 0);
    cyc(0, 1, 1, 8'h77, 0, 0, 0, 0);
    idle(1); idle(0);

    cur_req = "R9";
    set_sp(16'h0061);
    cyc(0, 0, 0, 8'h00, 1, 0, 0, 0);
    cyc(0, 0, 0, 8'h00, 1, 0, 0, 0);
    cyc(0, 0, 0, 8'h00, 1, 0, 0, 0);
    idle(0);
    set_sp(16'h0060);
    cyc(0, 0, 0, 8'h00, 0, 0, 1, 0);
    idle(0);
    cyc(0, 0, 0, 8'h00, 0, 1, 0, 0);
    idle(0);

    cur_req = "R10";
    set_sp(16'h0000);
    cyc(0, 0, 1, 8'h00, 1, 0, 0, 0);
    idle(1); idle(0);
    cyc(0, 0, 0, 8'h00, 0, 1, 0, 0);
    idle(1);
    set_sp(16'h0001);
    cyc(0, 0, 0, 8'h00, 0, 0, 1, 0);
    idle(1); idle(0);
    cyc(0, 0, 0, 8'h00, 0, 0, 0, 1);
    idle(1);

    cur_req = "R1";
    cyc(1, 0, 0, 8'h00, 0, 0, 0, 0);
    idle(0); idle(1);

    summary();
  end
endmodule